// File: doc/BRIEF.md
# Crosspoint Switch Control Registers

This block is the digital front end of an eight-output, eight-input crosspoint switch. Each output has a route entry. The entry holds a 3-bit input select and an enable bit. Route entries are written into a first rank of storage, and a second rank holds the routes that are live. The second rank feeds a decoder. For each output, the decoder produces a one-hot vector that names the input to connect. The vector is all zeros when the output is disabled. Only this digital control is modelled. The analog path is not part of the block.

Entries can be loaded in two ways. In serial mode, one bit is shifted in per write strobe. A cascade output lets several devices form a single chain. In parallel mode, a 4-bit code and an output address are written per strobe. Some parallel codes act on every output at once. These codes also update the live rank in the same cycle. Another code copies the first rank to the live rank on request from software. Outside of commands, the live rank is loaded in one of two ways, chosen by a mode pin: on the rising edge of the latch pin, or continuously while the latch pin is low.

The write strobe and the latch pin are sampled on the block clock, and their rising edges are detected internally.

Top module: `xpt_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both ranks clear. After that edge, every bit of `connect_o` is 0 and `ser_out` is 0.
- R2: A write in parallel mode (`ser_mode`=0) with a code from 0 to 7 sets the addressed entry to enabled, with the select equal to the code. After transfer, `connect_o[k*8+j]` is 1 only for output k=`addr` and input j=code.
- R3: The parallel code 8 disables the addressed output. After transfer, its 8-bit slice of `connect_o` is zero.
- R4: The parallel codes 9 and 10 change neither rank.
- R5: When `edge_mode`=1, the live rank takes the first rank only at a rising edge of `latch_in`. A write with a code from 0 to 10 leaves `connect_o` unchanged. A steady high or low level on `latch_in` also leaves it unchanged.
- R6: When `edge_mode`=0 and `latch_in` is low, the live rank follows the first rank one clock later. While `latch_in` is high, the live rank holds.
- R7: The parallel code 11 clears the enable of every output and keeps each select. The new contents reach both ranks at the edge that samples the write, regardless of `latch_in`.
- R8: The parallel code 12 sets the enable of every output and keeps each select. It writes both ranks at once.
- R9: The parallel code 13 routes every output to the input numbered by `addr`, with every output enabled. It writes both ranks at once.
- R10: The parallel code 14 routes output k to input k for every output, with every output enabled. It writes both ranks at once.
- R11: The parallel code 15 copies the first rank into the live rank at the edge that samples the write, but only if `latch_in` is high. With `latch_in` low, it has no effect when `edge_mode`=1.
- R12: In serial mode, each rising edge of `wr_strobe` shifts `data_in[0]` into bit 0 of a 32-bit chain. The shift moves every bit one place up. Output k uses chain bits [4k+3:4k], laid out as {enable, select[2:0]}. The first of 32 bits lands on the enable bit of output 7. Shifting does not touch the live rank.
- R13: In serial mode, `ser_out` carries chain bit 31. In parallel mode, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_mode | input | 1 | 1 selects serial entry, 0 selects parallel entry |
| edge_mode | input | 1 | 1 selects edge-triggered transfer to the live rank, 0 selects level-transparent transfer |
| wr_strobe | input | 1 | Write strobe; acts on its rising edge |
| latch_in | input | 1 | Transfer control for the live rank |
| addr | input | 3 | Output address for parallel writes; input number for code 13 |
| data_in | input | 4 | Parallel code; bit 0 is the serial data input |
| ser_out | output | 1 | Cascade output of the serial chain |
| connect_o | output | 64 | Slice [8k+7:8k] is the one-hot input selection for output k |

## Verification
Take the edge that first samples a strobe or latch rise. At that edge, the first rank updates. So do the edge-mode transfers, codes 11 to 15, and therefore `connect_o`, since `connect_o` is decoded straight from the live rank. In level mode the live rank follows one edge later. The bench changes inputs on the falling edge and samples on the next falling edge, which gives exactly one rising edge between them. Level-mode checks wait one further falling edge. To show the one-cycle lag, they also check the old value at the first falling edge.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Width of the parallel data/command field (fixed by the code set below)
    localparam int CODE_W = 4;

    // Command codes carried in the data field; codes below 8 are plain selects
    typedef enum logic [CODE_W-1:0] {
        CMD_OFF_ONE  = 4'b1000,
        CMD_RSVD_9   = 4'b1001,
        CMD_RSVD_10  = 4'b1010,
        CMD_ALL_OFF  = 4'b1011,
        CMD_ALL_ON   = 4'b1100,
        CMD_BCAST    = 4'b1101,
        CMD_IDENT    = 4'b1110,
        CMD_SW_LATCH = 4'b1111
    } xpt_cmd_e;

endpackage

// File: rtl/xpt_edge_det.sv
module xpt_edge_det (
    input  logic clk,
    input  logic sig_i,
    output logic rise_o
);
    // The previous sample always tracks the input, so reset never hides an edge
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        prev_q <= prev_d;
    end
endmodule

// File: rtl/xpt_cmd_decode.sv
module xpt_cmd_decode
    import xpt_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int N_IN  = 8
) (
    input  logic [CODE_W-1:0]                           code_i,
    input  logic [$clog2(N_OUT)-1:0]                    addr_i,
    input  logic [N_OUT*($clog2(N_IN)+1)-1:0]           rank1_i,
    output logic [N_OUT*($clog2(N_IN)+1)-1:0]           rank1_o,
    output logic                                        commit_o,
    output logic                                        swlatch_o
);
    localparam int SEL_W   = $clog2(N_IN);
    localparam int ENTRY_W = SEL_W + 1;

    always_comb begin
        rank1_o   = rank1_i;
        commit_o  = 1'b0;
        swlatch_o = 1'b0;
        if (!code_i[CODE_W-1]) begin
            // plain select: enable addressed output on the given input
            rank1_o[addr_i*ENTRY_W +: ENTRY_W] = {1'b1, code_i[SEL_W-1:0]};
        end else begin
            case (code_i)
                CMD_OFF_ONE: rank1_o[addr_i*ENTRY_W +: ENTRY_W] = '0;
                CMD_ALL_OFF: begin
                    for (int k = 0; k < N_OUT; k++) rank1_o[k*ENTRY_W + SEL_W] = 1'b0;
                    commit_o = 1'b1;
                end
                CMD_ALL_ON: begin
                    for (int k = 0; k < N_OUT; k++) rank1_o[k*ENTRY_W + SEL_W] = 1'b1;
                    commit_o = 1'b1;
                end
                CMD_BCAST: begin
                    for (int k = 0; k < N_OUT; k++)
                        rank1_o[k*ENTRY_W +: ENTRY_W] = {1'b1, SEL_W'(addr_i)};
                    commit_o = 1'b1;
                end
                CMD_IDENT: begin
                    for (int k = 0; k < N_OUT; k++)
                        rank1_o[k*ENTRY_W +: ENTRY_W] = {1'b1, SEL_W'(k)};
                    commit_o = 1'b1;
                end
                CMD_SW_LATCH: swlatch_o = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xpt_out_decode.sv
module xpt_out_decode #(
    parameter int N_OUT = 8,
    parameter int N_IN  = 8
) (
    input  logic [N_OUT*($clog2(N_IN)+1)-1:0] rank2_i,
    output logic [N_OUT*N_IN-1:0]             connect_o
);
    localparam int SEL_W   = $clog2(N_IN);
    localparam int ENTRY_W = SEL_W + 1;

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic             en;
        logic [SEL_W-1:0] sel;
        assign en  = rank2_i[k*ENTRY_W + SEL_W];
        assign sel = rank2_i[k*ENTRY_W +: SEL_W];
        always_comb begin
            connect_o[k*N_IN +: N_IN] = '0;
            for (int j = 0; j < N_IN; j++)
                if (en && sel == SEL_W'(j)) connect_o[k*N_IN + j] = 1'b1;
        end
    end
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
    import xpt_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int N_IN  = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ser_mode,
    input  logic                        edge_mode,
    input  logic                        wr_strobe,
    input  logic                        latch_in,
    input  logic [$clog2(N_OUT)-1:0]    addr,
    input  logic [CODE_W-1:0]           data_in,
    output logic                        ser_out,
    output logic [N_OUT*N_IN-1:0]       connect_o
);
    localparam int SEL_W   = $clog2(N_IN);
    localparam int ENTRY_W = SEL_W + 1;
    localparam int CHAIN_W = N_OUT * ENTRY_W;

    typedef struct packed {
        logic [CHAIN_W-1:0] rank1;
        logic [CHAIN_W-1:0] rank2;
    } state_t;

    state_t st_d, st_q;

    logic               wr_rise, lat_rise;
    logic [CHAIN_W-1:0] cmd_rank1;
    logic               cmd_commit, cmd_swlatch;
    logic               par_wr, hw_xfer;

    xpt_edge_det u_wr_edge  (.clk(clk), .sig_i(wr_strobe), .rise_o(wr_rise));
    xpt_edge_det u_lat_edge (.clk(clk), .sig_i(latch_in),  .rise_o(lat_rise));

    xpt_cmd_decode #(.N_OUT(N_OUT), .N_IN(N_IN)) u_cmd (
        .code_i   (data_in),
        .addr_i   (addr),
        .rank1_i  (st_q.rank1),
        .rank1_o  (cmd_rank1),
        .commit_o (cmd_commit),
        .swlatch_o(cmd_swlatch)
    );

    always_comb begin
        st_d    = st_q;
        par_wr  = wr_rise & ~ser_mode;
        hw_xfer = edge_mode ? lat_rise : ~latch_in;

        if (wr_rise) begin
            if (ser_mode) st_d.rank1 = {st_q.rank1[CHAIN_W-2:0], data_in[0]};
            else          st_d.rank1 = cmd_rank1;
        end

        // live rank: commands first, then software latch, then pin-driven transfer
        if (par_wr && cmd_commit)                 st_d.rank2 = cmd_rank1;
        else if (par_wr && cmd_swlatch && latch_in) st_d.rank2 = st_q.rank1;
        else if (hw_xfer)                         st_d.rank2 = st_q.rank1;

        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ser_out = ser_mode & st_q.rank1[CHAIN_W-1];

    xpt_out_decode #(.N_OUT(N_OUT), .N_IN(N_IN)) u_dec (
        .rank2_i  (st_q.rank2),
        .connect_o(connect_o)
    );
endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk #(
    parameter int N_OUT = 8,
    parameter int N_IN  = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ser_mode,
    input logic                  edge_mode,
    input logic                  wr_strobe,
    input logic                  latch_in,
    input logic [3:0]            data_in,
    input logic [N_OUT*N_IN-1:0] connect_o
);
    function automatic logic [N_OUT*N_IN-1:0] ident_map();
        logic [N_OUT*N_IN-1:0] m;
        m = '0;
        for (int k = 0; k < N_OUT; k++) m[k*N_IN + (k % N_IN)] = 1'b1;
        return m;
    endfunction

    localparam logic [N_OUT*N_IN-1:0] IDENT_MAP = ident_map();

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> connect_o == '0); // R1

    for (genvar k = 0; k < N_OUT; k++) begin : g_oh
        AST_ONE_INPUT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(connect_o[k*N_IN +: N_IN])); // R2
    end

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && !(latch_in && !$past(latch_in)) && !(wr_strobe && !$past(wr_strobe)))
        |=> $stable(connect_o)); // R5

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && latch_in && !(wr_strobe && !$past(wr_strobe)))
        |=> $stable(connect_o)); // R6

    AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && wr_strobe && !$past(wr_strobe) && data_in == 4'b1011)
        |=> connect_o == '0); // R7

    AST_IDENT_MAP: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && wr_strobe && !$past(wr_strobe) && data_in == 4'b1110)
        |=> connect_o == IDENT_MAP); // R10
endmodule

bind xpt_ctrl xpt_ctrl_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_mode (ser_mode),
    .edge_mode(edge_mode),
    .wr_strobe(wr_strobe),
    .latch_in (latch_in),
    .data_in  (data_in),
    .connect_o(connect_o)
);

// File: tb/xpt_ctrl_bench.sv
module xpt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst, ser_mode, edge_mode, wr_strobe, latch_in, ser_out;
    logic [2:0]  addr;
    logic [3:0]  data_in;
    logic [63:0] connect_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xpt_ctrl u_xpt_ctrl (
        .clk(clk), .rst(rst), .ser_mode(ser_mode), .edge_mode(edge_mode),
        .wr_strobe(wr_strobe), .latch_in(latch_in), .addr(addr),
        .data_in(data_in), .ser_out(ser_out), .connect_o(connect_o)
    );

    typedef struct packed {
        logic       lat;   // 1: latch pulse, 0: parallel write
        logic [2:0] a;
        logic [3:0] d;
        logic [2:0] chk;   // output slice to check
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd3, 4'd5,  3'd3, 8'h00},  // R5 write not yet live
        '{1'b1, 3'd0, 4'd0,  3'd3, 8'h20},  // R2 latch edge
        '{1'b0, 3'd3, 4'd8,  3'd3, 8'h20},  // R5
        '{1'b1, 3'd0, 4'd0,  3'd3, 8'h00},  // R3
        '{1'b0, 3'd0, 4'd7,  3'd0, 8'h00},  // R5
        '{1'b1, 3'd0, 4'd0,  3'd0, 8'h80},  // R2
        '{1'b0, 3'd0, 4'd9,  3'd0, 8'h80},  // R4
        '{1'b1, 3'd0, 4'd0,  3'd0, 8'h80},  // R4
        '{1'b0, 3'd0, 4'd10, 3'd0, 8'h80},  // R4
        '{1'b1, 3'd0, 4'd0,  3'd0, 8'h80},  // R4
        '{1'b0, 3'd2, 4'd13, 3'd5, 8'h04},  // R9
        '{1'b0, 3'd0, 4'd14, 3'd6, 8'h40},  // R10
        '{1'b0, 3'd0, 4'd11, 3'd6, 8'h00},  // R7
        '{1'b0, 3'd0, 4'd12, 3'd6, 8'h40}   // R8
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; data_in = d; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        latch_in = 1'b1;
        @(negedge clk);
        latch_in = 1'b0;
    endtask

    function automatic logic [7:0] slice(input logic [2:0] k);
        return connect_o[k*8 +: 8];
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        rst = 1'b1; ser_mode = 1'b0; edge_mode = 1'b1; wr_strobe = 1'b0;
        latch_in = 1'b0; addr = '0; data_in = '0;
        repeat (3) @(negedge clk);
        check("R1 reset connect", connect_o, 64'h0);
        check("R1 reset ser_out", {63'h0, ser_out}, 64'h0);
        rst = 1'b0;

        // table walk, edge mode, parallel entry
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].lat) latch_pulse();
            else            do_write(VEC[i].a, VEC[i].d);
            check($sformatf("table row %0d", i), {56'h0, slice(VEC[i].chk)}, {56'h0, VEC[i].exp});
        end

        // R5 held-high latch, R11 software latch
        @(negedge clk); latch_in = 1'b1;
        @(negedge clk);
        do_write(3'd1, 4'd4);
        check("R5 latch held high", {56'h0, slice(3'd1)}, 64'h02);
        do_write(3'd0, 4'd15);
        check("R11 sw latch high", {56'h0, slice(3'd1)}, 64'h10);
        @(negedge clk); latch_in = 1'b0;
        @(negedge clk);
        do_write(3'd1, 4'd6);
        do_write(3'd0, 4'd15);
        check("R11 sw latch low ignored", {56'h0, slice(3'd1)}, 64'h10);

        // R6 level mode
        @(negedge clk); edge_mode = 1'b0;
        @(negedge clk);
        check("R6 transparent follow", {56'h0, slice(3'd1)}, 64'h40);
        do_write(3'd4, 4'd1);
        check("R6 one-cycle lag", {56'h0, slice(3'd4)}, 64'h10);
        @(negedge clk);
        check("R6 followed", {56'h0, slice(3'd4)}, 64'h02);
        latch_in = 1'b1;
        do_write(3'd4, 4'd2);
        @(negedge clk);
        check("R6 hold while high", {56'h0, slice(3'd4)}, 64'h02);
        latch_in = 1'b0;
        @(negedge clk);
        check("R6 release", {56'h0, slice(3'd4)}, 64'h04);

        // R12 serial chain, R13 cascade output
        @(negedge clk); edge_mode = 1'b1; ser_mode = 1'b1;
        w = '0;
        for (int k = 0; k < 8; k++) w[k*4 +: 4] = {1'b1, 3'(7 - k)};
        for (int b = 31; b >= 0; b--) do_write(3'd0, {3'b0, w[b]});
        check("R12 shift not live", {56'h0, slice(3'd0)}, 64'h01);
        latch_pulse();
        for (int k = 0; k < 8; k++)
            check($sformatf("R12 serial out%0d", k), {56'h0, slice(3'(k))}, 64'(8'h1 << (7 - k)));
        check("R13 ser_out chain msb", {63'h0, ser_out}, 64'h1);
        @(negedge clk); ser_mode = 1'b0;
        #1 check("R13 ser_out parallel", {63'h0, ser_out}, 64'h0);
        @(negedge clk); ser_mode = 1'b1;
        do_write(3'd0, 4'd0);
        check("R13 ser_out after 1", {63'h0, ser_out}, {63'h0, w[30]});
        for (int b = 0; b < 3; b++) do_write(3'd0, 4'd0);
        check("R13 ser_out after 4", {63'h0, ser_out}, {63'h0, w[27]});

        // R1 reset again from a loaded state
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears live", connect_o, 64'h0);
        check("R1 reset clears chain", {63'h0, ser_out}, 64'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule